// File: doc/BRIEF.md
# Four-Sided Routing Switch Box

This block sits at the crossing of four 4-bit routing channels (west, east, north and south) in a programmable fabric. Each of its sixteen output tracks picks one track from one of the other three sides through a fixed, deliberately scrambled wiring pattern. The most significant west output and the most significant east output can also pick a single-bit signal from a neighbouring logic block. Whether a track is routed, and from where, is set by a 2-bit selector for that output bit.

The sixteen selectors sit in a 32-bit serial shift chain. The chain loads on the rising edge of a dedicated scan clock while the enable is high. Its last stage drives a serial output, so tiles can be daisy-chained and the loaded pattern can be read back. Once the chain is loaded, the routing path is purely combinational from track inputs to track outputs. An active-high asynchronous reset empties the chain, which routes every output to its first choice.

Top module: `route_switch4`

## Requirements
- R1: While `cfg_en` is high, each rising `clk_scan` edge moves `cfg_din` into chain bit 0 and every chain bit up by one place. Selector field k (k = 0..15) is chain bits [2k+1:2k], with bit 2k the least significant. Fields 0..3 drive west bits 0..3, fields 4..7 east bits 0..3, fields 8..11 north bits 0..3 and fields 12..15 south bits 0..3. After 32 enabled edges, the bit presented at edge j (j = 1..32) sits in chain bit 32−j.
- R2: While `cfg_en` is low, scan clock edges leave every selector unchanged, whatever `cfg_din` does.
- R3: While `rst` is high, every selector is 0 and `cfg_dout` is 0, so each output follows its selector-0 source.
- R4: West output bit b takes, for selector 0/1/2: bit 0 → south[2]/north[1]/east[0]; bit 1 → south[1]/north[2]/east[1]; bit 2 → south[0]/north[3]/east[2]; bit 3 → south[3]/north[0]/east[3].
- R5: East output bit b takes, for selector 0/1/2: bit 0 → south[3]/north[2]/west[0]; bit 1 → south[0]/north[1]/west[1]; bit 2 → south[1]/north[0]/west[2]; bit 3 → south[2]/north[3]/west[3].
- R6: North output bit b takes, for selector 0/1/2: bit 0 → south[0]/east[2]/west[3]; bit 1 → south[1]/east[1]/west[0]; bit 2 → south[2]/east[0]/west[1]; bit 3 → south[3]/east[3]/west[2].
- R7: South output bit b takes, for selector 0/1/2: bit 0 → north[0]/east[1]/west[2]; bit 1 → north[1]/east[2]/west[1]; bit 2 → north[2]/east[3]/west[0]; bit 3 → north[3]/east[0]/west[3].
- R8: Selector value 3 drives 0 on every output bit except west bit 3 and east bit 3.
- R9: Selector value 3 routes `west_lb` to west bit 3 and `east_lb` to east bit 3.
- R10: `cfg_dout` shows chain bit 31. Shifting 32 new bits in presents the previously loaded bits on `cfg_dout` in the order they were loaded, bit 31 first.
- R11: Track outputs follow track and logic-block inputs combinationally, without a scan clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_scan | input | 1 | Configuration shift clock |
| rst | input | 1 | Active-high asynchronous clear of all selectors |
| cfg_en | input | 1 | Shift enable for the selector chain |
| cfg_din | input | 1 | Serial configuration input |
| cfg_dout | output | 1 | Serial output, last stage of the chain |
| west_in | input | 4 | Tracks arriving from the west channel |
| east_in | input | 4 | Tracks arriving from the east channel |
| north_in | input | 4 | Tracks arriving from the north channel |
| south_in | input | 4 | Tracks arriving from the south channel |
| west_lb | input | 1 | Logic-block signal offered to west bit 3 |
| east_lb | input | 1 | Logic-block signal offered to east bit 3 |
| west_out | output | 4 | Tracks driven into the west channel |
| east_out | output | 4 | Tracks driven into the east channel |
| north_out | output | 4 | Tracks driven into the north channel |
| south_out | output | 4 | Tracks driven into the south channel |

## Verification
A selector that is corrupt, shifted by one place or swapped between fields shows at the ports as soon as the chain stops shifting. An output bit then carries a track from the wrong side, from the wrong index, or a constant 0. The sweeps drive many random track patterns for each selector value, so a wrong tap is seen within a few vectors. A chain fault that leaves the routing intact still shows on `cfg_dout`: the 32-edge readback reproduces the loaded stream only if every stage shifts correctly.

// File: rtl/swb_pkg.sv
`timescale 1ns/1ps
package swb_pkg;

  typedef enum logic [1:0] {SIDE_W, SIDE_E, SIDE_N, SIDE_S} side_e;

  // Track permutations, packed as 2-bit tap indices for bits 3..0.
  localparam logic [7:0] PERM_I = 8'hE4; // 0,1,2,3
  localparam logic [7:0] PERM_A = 8'hC6; // 2,1,0,3
  localparam logic [7:0] PERM_B = 8'h39; // 1,2,3,0
  localparam logic [7:0] PERM_C = 8'h93; // 3,0,1,2

  function automatic logic [7:0] perm_code(side_e side, int unsigned choice);
    logic [7:0] c;
    c = PERM_I;
    case (side)
      SIDE_W: c = (choice == 0) ? PERM_A : (choice == 1) ? PERM_B : PERM_I;
      SIDE_E: c = (choice == 0) ? PERM_C : (choice == 1) ? PERM_A : PERM_I;
      SIDE_N: c = (choice == 0) ? PERM_I : (choice == 1) ? PERM_A : PERM_C;
      SIDE_S: c = (choice == 0) ? PERM_I : (choice == 1) ? PERM_B : PERM_A;
      default: c = PERM_I;
    endcase
    return c;
  endfunction

  // Source track index for output bit b of a side under a given choice.
  function automatic int unsigned tap(side_e side, int unsigned choice, int unsigned b);
    logic [7:0] c;
    c = perm_code(side, choice);
    return int'(c[2*b +: 2]);
  endfunction

endpackage

// File: rtl/swb_cfg_chain.sv
`timescale 1ns/1ps
module swb_cfg_chain #(
  parameter int LEN = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           din,
  output logic [LEN-1:0] q,
  output logic           dout
);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)
      q <= '0;
    else if (en)
      q <= {q[LEN-2:0], din};
  end

  assign dout = q[LEN-1];

  // R1: new bit enters at the bottom, the rest move up one place
  a_r1_shift: assert property (@(posedge clk) disable iff (rst)
    en |=> (q[0] == $past(din)) && (q[LEN-1:1] == $past(q[LEN-2:0])));

  // R2: no enable, no change
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));

  // R3: after a reset cycle the chain is empty
  a_r3_clear: assert property (@(posedge clk)
    $past(rst) |-> (q == '0));

endmodule

// File: rtl/swb_side_mux.sv
`timescale 1ns/1ps
module swb_side_mux
  import swb_pkg::*;
#(
  parameter side_e SIDE  = SIDE_W,
  parameter int    CH_W  = 4,
  parameter int    SEL_W = 2
) (
  input  logic [CH_W-1:0]       src0,
  input  logic [CH_W-1:0]       src1,
  input  logic [CH_W-1:0]       src2,
  input  logic                  lb,
  input  logic [CH_W*SEL_W-1:0] sel,
  output logic [CH_W-1:0]       dout
);

  for (genvar g = 0; g < CH_W; g++) begin : g_bit
    localparam int unsigned T0 = tap(SIDE, 0, g);
    localparam int unsigned T1 = tap(SIDE, 1, g);
    localparam int unsigned T2 = tap(SIDE, 2, g);

    logic [SEL_W-1:0] s;
    logic             extra;
    logic             o;

    assign s = sel[g*SEL_W +: SEL_W];

    if (g == CH_W-1) begin : g_lb
      assign extra = lb;
    end else begin : g_zero
      assign extra = 1'b0;
    end

    always_comb begin
      case (s)
        SEL_W'(0): o = src0[T0];
        SEL_W'(1): o = src1[T1];
        SEL_W'(2): o = src2[T2];
        default:   o = extra;
      endcase
    end

    assign dout[g] = o;
  end

endmodule

// File: rtl/route_switch4.sv
`timescale 1ns/1ps
module route_switch4
  import swb_pkg::*;
#(
  parameter int CH_W  = 4,
  parameter int SEL_W = 2
) (
  input  logic            clk_scan,
  input  logic            rst,
  input  logic            cfg_en,
  input  logic            cfg_din,
  output logic            cfg_dout,
  input  logic [CH_W-1:0] west_in,
  input  logic [CH_W-1:0] east_in,
  input  logic [CH_W-1:0] north_in,
  input  logic [CH_W-1:0] south_in,
  input  logic            west_lb,
  input  logic            east_lb,
  output logic [CH_W-1:0] west_out,
  output logic [CH_W-1:0] east_out,
  output logic [CH_W-1:0] north_out,
  output logic [CH_W-1:0] south_out
);

  localparam int N_OUT     = 4 * CH_W;
  localparam int SIDE_BITS = CH_W * SEL_W;
  localparam int CHAIN_LEN = N_OUT * SEL_W;

  logic [CHAIN_LEN-1:0] sel_chain;
  logic [N_OUT-1:0]     all_out;

  swb_cfg_chain #(.LEN(CHAIN_LEN)) u_chain (
    .clk (clk_scan),
    .rst (rst),
    .en  (cfg_en),
    .din (cfg_din),
    .q   (sel_chain),
    .dout(cfg_dout)
  );

  swb_side_mux #(.SIDE(SIDE_W), .CH_W(CH_W), .SEL_W(SEL_W)) u_west (
    .src0(south_in), .src1(north_in), .src2(east_in), .lb(west_lb),
    .sel (sel_chain[0*SIDE_BITS +: SIDE_BITS]), .dout(west_out)
  );

  swb_side_mux #(.SIDE(SIDE_E), .CH_W(CH_W), .SEL_W(SEL_W)) u_east (
    .src0(south_in), .src1(north_in), .src2(west_in), .lb(east_lb),
    .sel (sel_chain[1*SIDE_BITS +: SIDE_BITS]), .dout(east_out)
  );

  swb_side_mux #(.SIDE(SIDE_N), .CH_W(CH_W), .SEL_W(SEL_W)) u_north (
    .src0(south_in), .src1(east_in), .src2(west_in), .lb(1'b0),
    .sel (sel_chain[2*SIDE_BITS +: SIDE_BITS]), .dout(north_out)
  );

  swb_side_mux #(.SIDE(SIDE_S), .CH_W(CH_W), .SEL_W(SEL_W)) u_south (
    .src0(north_in), .src1(east_in), .src2(west_in), .lb(1'b0),
    .sel (sel_chain[3*SIDE_BITS +: SIDE_BITS]), .dout(south_out)
  );

  assign all_out = {south_out, north_out, east_out, west_out};

  // R10: the serial output carries the stage just below the top after a shift
  a_r10_tail: assert property (@(posedge clk_scan) disable iff (rst)
    cfg_en |=> (cfg_dout == $past(sel_chain[CHAIN_LEN-2])));

  for (genvar k = 0; k < N_OUT; k++) begin : g_chk
    logic [SEL_W-1:0] fld;
    assign fld = sel_chain[k*SEL_W +: SEL_W];

    if (k == CH_W-1) begin : g_wlb
      // R9: west top bit takes its logic-block input on selector 3
      a_r9_west_lb: assert property (@(posedge clk_scan) disable iff (rst)
        (fld == SEL_W'(3)) |-> (all_out[k] == west_lb));
    end else if (k == 2*CH_W-1) begin : g_elb
      // R9: east top bit takes its logic-block input on selector 3
      a_r9_east_lb: assert property (@(posedge clk_scan) disable iff (rst)
        (fld == SEL_W'(3)) |-> (all_out[k] == east_lb));
    end else begin : g_idle
      // R8: unused selector value parks the output at 0
      a_r8_idle_zero: assert property (@(posedge clk_scan) disable iff (rst)
        (fld == SEL_W'(3)) |-> (all_out[k] == 1'b0));
    end

    if (k < CH_W) begin : g_wpass
      // R4: west choice 2 passes the same-index east track straight across
      a_r4_west_pass: assert property (@(posedge clk_scan) disable iff (rst)
        (fld == SEL_W'(2)) |-> (all_out[k] == east_in[k]));
    end
  end

endmodule

// File: tb/sim_route_switch4.sv
`timescale 1ns/1ps
module sim_route_switch4;

  logic       clk_scan = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_en = 1'b0;
  logic       cfg_din = 1'b0;
  logic       cfg_dout;
  logic [3:0] west_in = '0, east_in = '0, north_in = '0, south_in = '0;
  logic       west_lb = 1'b0, east_lb = 1'b0;
  logic [3:0] west_out, east_out, north_out, south_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_scan = ~clk_scan;  // 250 MHz

  route_switch4 u0 (
    .clk_scan(clk_scan), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .cfg_dout(cfg_dout),
    .west_in(west_in), .east_in(east_in), .north_in(north_in), .south_in(south_in),
    .west_lb(west_lb), .east_lb(east_lb),
    .west_out(west_out), .east_out(east_out), .north_out(north_out), .south_out(south_out)
  );

  // Independent model of one output bit: side 0 west, 1 east, 2 north, 3 south
  function automatic logic model(int sd, int b, int s);
    int rv;
    rv = (b == 3) ? 3 : 2 - b;
    if (s == 3) begin
      if (b == 3 && sd == 0) return west_lb;
      if (b == 3 && sd == 1) return east_lb;
      return 1'b0;
    end
    case (sd)
      0: return (s == 0) ? south_in[rv] : (s == 1) ? north_in[(b+1)%4] : east_in[b];
      1: return (s == 0) ? south_in[(b+3)%4] : (s == 1) ? north_in[rv] : west_in[b];
      2: return (s == 0) ? south_in[b] : (s == 1) ? east_in[rv] : west_in[(b+3)%4];
      default: return (s == 0) ? north_in[b] : (s == 1) ? east_in[(b+1)%4] : west_in[rv];
    endcase
  endfunction

  function automatic logic actual(int sd, int b);
    case (sd)
      0: return west_out[b];
      1: return east_out[b];
      2: return north_out[b];
      default: return south_out[b];
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_outputs(logic [31:0] cfg, string base);
    for (int sd = 0; sd < 4; sd++) begin
      for (int b = 0; b < 4; b++) begin
        int s;
        string req;
        s = int'(cfg[2*(sd*4+b) +: 2]);
        if (s == 3) req = (b == 3 && sd < 2) ? "R9" : "R8";
        else if (sd == 0) req = "R4";
        else if (sd == 1) req = "R5";
        else if (sd == 2) req = "R6";
        else req = "R7";
        chk(req, $sformatf("%s side%0d bit%0d sel%0d", base, sd, b, s),
            {31'd0, actual(sd, b)}, {31'd0, model(sd, b, s)});
      end
    end
  endtask

  // R11: inputs change between edges, outputs checked 1 ns later
  task automatic sweep(logic [31:0] cfg, int n, string base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_scan);
      {west_in, east_in, north_in, south_in} = 16'($urandom);
      {west_lb, east_lb} = 2'($urandom);
      #1;
      check_outputs(cfg, base);
    end
  endtask

  task automatic load(logic [31:0] cfg);
    for (int i = 31; i >= 0; i--) begin
      @(negedge clk_scan);
      cfg_en = 1'b1;
      cfg_din = cfg[i];
    end
    @(negedge clk_scan);
    cfg_en = 1'b0;
  endtask

  initial begin
    logic [31:0] cfg, nxt, got;

    repeat (3) @(negedge clk_scan);
    chk("R3", "dout in reset", {31'd0, cfg_dout}, 32'd0);
    sweep(32'd0, 8, "reset held");
    @(negedge clk_scan);
    rst = 1'b0;
    sweep(32'd0, 8, "after reset R3");

    // uniform selector values
    for (int c = 0; c < 4; c++) begin
      cfg = {16{2'(c)}};
      load(cfg);
      chk("R1", "dout after load", {31'd0, cfg_dout}, {31'd0, cfg[31]});
      sweep(cfg, 64, "uniform");
    end

    // mixed per-field patterns, field order and layout R1
    for (int p = 0; p < 8; p++) begin
      cfg = '0;
      for (int k = 0; k < 16; k++) begin
        if (p == 0) cfg[2*k +: 2] = 2'(k % 4);
        else if (p == 1) cfg[2*k +: 2] = 2'((k * 3 + 1) % 4);
        else cfg[2*k +: 2] = 2'($urandom);
      end
      load(cfg);
      chk("R1", "dout after mixed load", {31'd0, cfg_dout}, {31'd0, cfg[31]});
      sweep(cfg, 48, "mixed R1");
    end

    // R2: enable low, din toggling
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_scan);
      cfg_din = 1'($urandom);
    end
    chk("R2", "dout held", {31'd0, cfg_dout}, {31'd0, cfg[31]});
    sweep(cfg, 32, "hold R2");

    // R10: readback while loading a new pattern
    nxt = $urandom;
    got = '0;
    for (int j = 0; j < 32; j++) begin
      @(negedge clk_scan);
      got[31-j] = cfg_dout;
      cfg_en = 1'b1;
      cfg_din = nxt[31-j];
    end
    @(negedge clk_scan);
    cfg_en = 1'b0;
    chk("R10", "readback stream", got, cfg);
    sweep(nxt, 32, "after readback R10");

    // R3: reset in mid-run
    @(negedge clk_scan);
    rst = 1'b1;
    #1;
    chk("R3", "dout after mid reset", {31'd0, cfg_dout}, 32'd0);
    sweep(32'd0, 8, "mid reset R3");
    @(negedge clk_scan);
    rst = 1'b0;
    sweep(32'd0, 8, "post mid reset R3");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_scan);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule